// File: doc/BRIEF.md
# Strobe-Handshake FIFO Buffer

This block is a first-in first-out buffer of 64 words, each 9 bits wide. A producer writes by raising a shift-in strobe, and a consumer reads by raising a shift-out strobe. Plain empty and full flags are not used. Instead, an input-ready line and an output-ready line drop on every strobe and come back only when there is room or data. A producer or consumer can therefore hold its strobe high and wait. The block also reports half-full and full, and it has an asynchronous active-low master reset.

Both strobes are sampled levels. Each one passes through a synchronizer and an edge detector inside the block, and all logic runs on one clock. The data output is driven only while the output enable is high; a separate enable pin models a tri-state driver. Several copies can run side by side to make a wider word. In that case they share their strobes and reset, and their ready and status flags are combined with a logical AND.

Top module: `shift_fifo`

## Requirements
- R1: While rstN is low, the block is cleared from any state. After release, with both strobes low, inReady is 1 and outReady, halfFull and full are all 0.
- R2: A rising edge on shiftIn while inReady is high captures dataIn, and dataIn must be held stable while shiftIn is high. inReady then goes low. It returns high once shiftIn is low again and the buffer is not full.
- R3: outReady is high whenever a word is waiting and no read is in progress, and dataOut shows that head word and holds it steady. A rising edge on shiftOut consumes the word and drops outReady. outReady returns only after shiftOut is low again and a word remains.
- R4: Words leave in the same order in which they entered.
- R5: halfFull is 1 exactly when 32 or more words are stored.
- R6: full is 1 exactly when all 64 words are stored. full implies halfFull.
- R7: If shiftIn rises while the buffer is full, the word is held pending. It is written as soon as a read frees a slot, and inReady then goes high for exactly one clock while shiftIn is still high.
- R8: If shiftOut rises while the buffer is empty, the read is held pending. When a word arrives, outReady goes high for exactly one clock with that word on dataOut, and the word is then removed.
- R9: When outEn is 0, dataOutOe is 0 and dataOut is all zeros. When outEn is 1, dataOutOe is 1 and dataOut carries the head word.
- R10: With the default two-stage synchronizer, when shiftIn is first sampled high into an empty buffer, outReady is high with the word on dataOut after the fourth rising clock edge. No read strobe is needed.
- R11: If a write and a read complete in the same clock, the occupancy does not change and neither word is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous master reset, active low |
| shiftIn | input | 1 | Write strobe, acts on its rising edge |
| shiftOut | input | 1 | Read strobe, acts on its rising edge |
| outEn | input | 1 | Output enable, active high |
| dataIn | input | 9 | Word to write |
| dataOut | output | 9 | Head word, zero while outEn is low |
| dataOutOe | output | 1 | Tri-state enable for dataOut |
| inReady | output | 1 | Ready to accept a write |
| outReady | output | 1 | Head word valid on dataOut |
| halfFull | output | 1 | At least 32 words stored |
| full | output | 1 | 64 words stored |

## Verification
The bench goes after the two waiting cases. In one, a write strobe arrives while the buffer is full. A design that wrote it anyway would overwrite the oldest word. A design that never retried would leave the producer stalled, with inReady low for good. In the other, a read strobe arrives while the buffer is empty. A design that got this wrong would either miss the one-clock outReady pulse or leave the late word sitting in the buffer. The bench also checks the half-full and full thresholds at 31/32 and 63/64 words, fall-through latency into an empty buffer, and a write and read that complete in the same clock. An occupancy counter that mishandles that last case either drops or duplicates a word.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  // strobes issued by control to the datapath each clock
  typedef struct packed {
    logic capture;  // latch dataIn into the pending-word holder
    logic push;     // write holder into storage at the write pointer
    logic pop;      // advance the read pointer
  } fifoStrobe_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeIn,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic prevLevel;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= strobeIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], strobeIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= level;

  assign level = chain[STAGES-1];
  assign rise  = level & ~prevLevel;
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import shift_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        siLvl,
  input  logic        siRise,
  input  logic        soLvl,
  input  logic        soRise,
  output fifoStrobe_t strobe,
  output logic        inReady,
  output logic        outReady,
  output logic        halfFull,
  output logic        full
);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CW-1:0] count;
  logic wrPend, wrBlocked, wrAck;
  logic rdPend, rdBlocked, orPulse;
  logic isFull, nonEmpty, doWrite, doRead;

  always_comb begin
    isFull   = (count == CAP);
    nonEmpty = (count != '0);
    doWrite  = wrPend & ~isFull;
    // a read that waited on empty shows its word for one clock first
    doRead   = rdPend & nonEmpty & (~rdBlocked | orPulse);
    strobe.capture = siRise & ~wrPend;
    strobe.push    = doWrite;
    strobe.pop     = doRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wrPend    <= 1'b0;
      wrBlocked <= 1'b0;
      wrAck     <= 1'b0;
      rdPend    <= 1'b0;
      rdBlocked <= 1'b0;
      orPulse   <= 1'b0;
    end else begin
      count     <= count + CW'(doWrite) - CW'(doRead);
      wrPend    <= wrPend ? ~doWrite : siRise;
      wrBlocked <= wrPend & ~doWrite & (isFull | wrBlocked);
      wrAck     <= doWrite & wrBlocked;
      rdPend    <= rdPend ? ~doRead : soRise;
      rdBlocked <= rdPend & ~doRead & (~nonEmpty | rdBlocked);
      orPulse   <= rdPend & rdBlocked & nonEmpty & ~orPulse;
    end
  end

  assign inReady  = (~isFull & ~wrPend & ~siLvl) | wrAck;
  assign outReady = (nonEmpty & ~rdPend & ~soLvl) | orPulse;
  assign halfFull = (count >= HALF);
  assign full     = isFull;
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import shift_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] headWord
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [WIDTH-1:0] holdWord;
  logic [AW-1:0]    wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      holdWord <= '0;
    end else begin
      if (strobe.capture) holdWord <= dataIn;
      if (strobe.push)    wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)     rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (strobe.push) store[wrPtr] <= holdWord;

  assign headWord = store[rdPtr];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic             shiftOut,
  input  logic             outEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutOe,
  output logic             inReady,
  output logic             outReady,
  output logic             halfFull,
  output logic             full
);
  fifoStrobe_t      strobe;
  logic             siLvl, siRise, soLvl, soRise;
  logic [WIDTH-1:0] headWord;

  strobe_sync #(.STAGES(SYNC_STAGES)) uSiSync (
    .clk(clk), .rstN(rstN), .strobeIn(shiftIn), .level(siLvl), .rise(siRise));

  strobe_sync #(.STAGES(SYNC_STAGES)) uSoSync (
    .clk(clk), .rstN(rstN), .strobeIn(shiftOut), .level(soLvl), .rise(soRise));

  fifo_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .siLvl(siLvl), .siRise(siRise),
    .soLvl(soLvl), .soRise(soRise), .strobe(strobe),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .full(full));

  fifo_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn), .headWord(headWord));

  assign dataOut   = outEn ? headWord : '0;
  assign dataOutOe = outEn;
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             outEn,
  input logic [WIDTH-1:0] dataOut,
  input logic             dataOutOe,
  input logic             inReady,
  input logic             outReady,
  input logic             halfFull,
  input logic             full
);
  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outReady && !full && !halfFull));

  assert_head_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outReady && $past(outReady) && outEn && $past(outEn)) |-> $stable(dataOut));

  assert_full_implies_half_R6: assert property (@(posedge clk) disable iff (!rstN)
    full |-> halfFull);

  assert_accept_pulse_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && full) |=> !(inReady && full));

  assert_output_disable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (!dataOutOe && dataOut == '0));
endmodule

bind shift_fifo shift_fifo_chk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .outEn(outEn), .dataOut(dataOut), .dataOutOe(dataOutOe),
  .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .full(full));

// File: tb/tb_shift_fifo.sv
`timescale 1ns/1ps
module tb_shift_fifo;
  localparam int W = 9;
  localparam int D = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftIn = 1'b0, shiftOut = 1'b0, outEn = 1'b1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic dataOutOe, inReady, outReady, halfFull, full;

  int total = 0;
  int bad = 0;
  bit cmpOn = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shift_fifo dut (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .shiftOut(shiftOut), .outEn(outEn),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutOe(dataOutOe), .inReady(inReady),
    .outReady(outReady), .halfFull(halfFull), .full(full));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of stored words plus handshake state bits
  logic [W-1:0] q[$];
  logic [W-1:0] mHold;
  bit mSi1, mSiL, mSiP, mSo1, mSoL, mSoP;
  bit mWrPend, mWrBlk, mWrAck, mRdPend, mRdBlk, mOrPulse;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); mHold = '0;
      {mSi1, mSiL, mSiP, mSo1, mSoL, mSoP} = '0;
      {mWrPend, mWrBlk, mWrAck, mRdPend, mRdBlk, mOrPulse} = '0;
    end else begin
      bit isFull, notEmpty, siR, soR, doW, doR, nWrBlk, nRdBlk, nOrP;
      isFull   = (q.size() == D);
      notEmpty = (q.size() != 0);
      siR = mSiL && !mSiP;
      soR = mSoL && !mSoP;
      doW = mWrPend && !isFull;
      doR = mRdPend && notEmpty && (!mRdBlk || mOrPulse);
      nWrBlk = mWrPend && !doW && (isFull || mWrBlk);
      nRdBlk = mRdPend && !doR && (!notEmpty || mRdBlk);
      nOrP   = mRdPend && mRdBlk && notEmpty && !mOrPulse;
      mWrAck = doW && mWrBlk;
      if (siR && !mWrPend) mHold = dataIn;
      if (doR) void'(q.pop_front());
      if (doW) q.push_back(mHold);
      mWrPend = mWrPend ? !doW : siR;
      mRdPend = mRdPend ? !doR : soR;
      mWrBlk = nWrBlk; mRdBlk = nRdBlk; mOrPulse = nOrP;
      mSiP = mSiL; mSiL = mSi1; mSi1 = shiftIn;
      mSoP = mSoL; mSoL = mSo1; mSo1 = shiftOut;
    end
  end

  // compare every clock, a quarter period after the edge
  always begin
    @(posedge clk);
    #5;
    if (rstN && cmpOn) begin
      bit eIR, eOR;
      eIR = ((q.size() != D) && !mWrPend && !mSiL) || mWrAck;
      eOR = ((q.size() != 0) && !mRdPend && !mSoL) || mOrPulse;
      check(inReady == eIR, "R2 inReady", inReady, eIR);
      check(outReady == eOR, "R3 outReady", outReady, eOR);
      check(halfFull == (q.size() >= D/2), "R5 halfFull", halfFull, q.size() >= D/2);
      check(full == (q.size() == D), "R6 full", full, q.size() == D);
      check(dataOutOe == outEn, "R9 dataOutOe", dataOutOe, outEn);
      if (q.size() != 0)
        check(dataOut == (outEn ? q[0] : '0), "R4 dataOut", dataOut, outEn ? q[0] : 0);
    end
  end

  task automatic pushWord(input logic [W-1:0] d);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    dataIn = d; shiftIn = 1'b1;
    repeat (4) @(negedge clk);
    shiftIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic popWord(output logic [W-1:0] d);
    @(negedge clk);
    while (!outReady) @(negedge clk);
    d = dataOut; shiftOut = 1'b1;
    repeat (4) @(negedge clk);
    shiftOut = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(i) ^ 9'h155;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] got;
    int n, pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
    check(outReady == 1'b0, "R1 outReady", outReady, 0);
    check(halfFull == 1'b0, "R1 halfFull", halfFull, 0);
    check(full == 1'b0, "R1 full", full, 0);
    cmpOn = 1'b1;

    // R10 fall-through latency into empty buffer
    dataIn = 9'h0A5; shiftIn = 1'b1; n = 0;
    do begin @(negedge clk); n++; end while (!outReady && n < 20);
    check(n == 4, "R10 latency", n, 4);
    check(dataOut == 9'h0A5, "R10 word", dataOut, 9'h0A5);
    shiftIn = 1'b0;
    repeat (3) @(negedge clk);
    popWord(got);
    check(got == 9'h0A5, "R2 first word", got, 9'h0A5);

    // R9 output enable
    pushWord(9'h17E);
    outEn = 1'b0; @(negedge clk);
    check(dataOut == '0 && dataOutOe == 1'b0, "R9 disabled", dataOut, 0);
    outEn = 1'b1; @(negedge clk);
    check(dataOut == 9'h17E && dataOutOe, "R9 enabled", dataOut, 9'h17E);
    popWord(got);

    // R5 / R6 thresholds while filling
    for (int i = 0; i < D; i++) begin
      pushWord(pat(i));
      if (i == 30) check(halfFull == 1'b0, "R5 31 words", halfFull, 0);
      if (i == 31) check(halfFull == 1'b1, "R5 32 words", halfFull, 1);
      if (i == 62) check(full == 1'b0, "R6 63 words", full, 0);
    end
    check(full == 1'b1 && inReady == 1'b0, "R6 64 words", full, 1);

    // R7 pending write while full
    @(negedge clk);
    dataIn = 9'h1AB; shiftIn = 1'b1;
    repeat (8) @(negedge clk);
    check(inReady == 1'b0 && full == 1'b1, "R7 held", inReady, 0);
    shiftOut = 1'b1; pulses = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 3) shiftOut = 1'b0;
      if (inReady) pulses++;
    end
    check(pulses == 1, "R7 ready pulse", pulses, 1);
    check(full == 1'b1, "R7 pending written", full, 1);
    shiftIn = 1'b0;
    repeat (4) @(negedge clk);

    // R4 drain in order
    for (int i = 1; i < D; i++) begin
      popWord(got);
      check(got == pat(i), "R4 order", got, pat(i));
    end
    popWord(got);
    check(got == 9'h1AB, "R7 late word", got, 9'h1AB);
    check(outReady == 1'b0, "R3 empty", outReady, 0);

    // R8 pending read while empty
    shiftOut = 1'b1;
    repeat (6) @(negedge clk);
    check(outReady == 1'b0, "R8 waiting", outReady, 0);
    dataIn = 9'h0C3; shiftIn = 1'b1; pulses = 0; got = '0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 3) shiftIn = 1'b0;
      if (outReady) begin pulses++; got = dataOut; end
    end
    check(pulses == 1, "R8 ready pulse", pulses, 1);
    check(got == 9'h0C3, "R8 word shown", got, 9'h0C3);
    shiftOut = 1'b0;
    repeat (4) @(negedge clk);
    check(outReady == 1'b0, "R8 word consumed", outReady, 0);

    // R11 write and read in the same clock
    pushWord(9'h011); pushWord(9'h022); pushWord(9'h033);
    @(negedge clk);
    dataIn = 9'h044; shiftIn = 1'b1; shiftOut = 1'b1;
    repeat (4) @(negedge clk);
    shiftIn = 1'b0; shiftOut = 1'b0;
    repeat (4) @(negedge clk);
    popWord(got); check(got == 9'h022, "R11 word b", got, 9'h022);
    popWord(got); check(got == 9'h033, "R11 word c", got, 9'h033);
    popWord(got); check(got == 9'h044, "R11 word d", got, 9'h044);
    check(outReady == 1'b0, "R11 empty after", outReady, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule